// File: doc/BRIEF.md
# DRAM ECC Error Logger

This block sits beside a DRAM controller's ECC check logic and records the error events it reports. Each class of error, correctable and uncorrectable, has a sticky bit in a first-error status register. The first event of a class latches the failing 4 KiB page into an address log. For a correctable event the block also latches the 16-bit syndrome and the memory channel decoded from it. Further events of a class whose first-error bit is still set only raise that class's bit in a next-error status register. The next-error bit marks that log information was lost.

Software reaches the block through a word-addressed register port with a combinational read path and single-cycle writes. Status bits are cleared by writing ones. The logs keep their contents until the matching first-error bit has been cleared and a new event of that class arrives. An interrupt line stays high while any status bit is set.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every status bit, both address logs, the syndrome log and the channel bit read as zero, and `irq` is low.
- R2: The first-error register (offset 0) and the next-error register (offset 1) both use bit 0 for correctable and bit 1 for uncorrectable errors. All other bits of these registers read as zero.
- R3: A correctable event that arrives while first-error bit 0 is clear sets that bit. In the same edge it latches address bits 33:12 into the correctable address log (offset 2, bits 27:6), the syndrome into the syndrome log (offset 4, bits 15:0) and the decoded channel into offset 5 bit 0.
- R4: An uncorrectable event that arrives while first-error bit 1 is clear sets that bit and latches address bits 33:12 into the uncorrectable address log (offset 3, bits 27:6).
- R5: An event of a class whose first-error bit is already set sets only that class's next-error bit. Every log keeps its contents.
- R6: A write to offset 0 or 1 clears each of bits 1:0 written as 1 and leaves each bit written as 0 unchanged. Such a write never alters a log.
- R7: After its first-error bit has been cleared, the next event of that class loads the logs again.
- R8: When an event and a clearing write hit the same status bit in the same cycle, the bit is set after that edge.
- R9: The channel is decoded from the syndrome in this order. If the upper byte is zero the channel is 0. Otherwise, if the lower byte is zero the channel is 1. Otherwise, if bits 15:12 or bits 11:8 are zero the channel is 0. In every other case the channel is 1.
- R10: Address log bits 31:28 and 5:0 always read as zero.
- R11: `irq` is high exactly while any of bits 1:0 of either status register is set.
- R12: Offsets 6 to 15 read as zero. Writes to offsets 2 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | One-cycle correctable error strobe |
| ue_evt | input | 1 | One-cycle uncorrectable error strobe |
| evt_addr | input | 34 | Physical address of the failing access |
| evt_syn | input | 16 | ECC syndrome of the correctable error |
| reg_addr | input | 4 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | High while any status bit is set |

## Verification
The assertions assume that `ce_evt` and `ue_evt` are synchronous one-cycle strobes and that `evt_addr` and `evt_syn` are valid in the cycle a strobe is high. They also assume that the register port's address and write strobe settle well before the clock edge. The bench drives every input one time unit after a rising edge and holds strobes for exactly one edge. It reads registers by changing only `reg_addr` between edges, so each read falls inside the window those assumptions describe.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   localparam int REG_AW = 4;
   localparam int DATA_W = 32;

   // word offsets of the register port
   localparam logic [REG_AW-1:0] OFS_FIRST   = 4'd0;
   localparam logic [REG_AW-1:0] OFS_NEXT    = 4'd1;
   localparam logic [REG_AW-1:0] OFS_CE_ADDR = 4'd2;
   localparam logic [REG_AW-1:0] OFS_UE_ADDR = 4'd3;
   localparam logic [REG_AW-1:0] OFS_SYN     = 4'd4;
   localparam logic [REG_AW-1:0] OFS_CHAN    = 4'd5;

   // bit positions inside both status registers
   localparam int BIT_CE = 0;
   localparam int BIT_UE = 1;

   typedef struct packed {
      logic ue;
      logic ce;
   } err_pair_t;
endpackage

// File: rtl/ecc_syn_chan.sv
module ecc_syn_chan #(
   parameter int SYN_W = 16
) (
   input  logic [SYN_W-1:0] syn,
   output logic             chan
);
   localparam int HALF = SYN_W / 2;
   localparam int NIB  = SYN_W / 4;

   if (SYN_W % 8 != 0 || SYN_W < 8) begin : g_bad_w
      $fatal(1, "ecc_syn_chan: SYN_W must be a multiple of 8");
   end

   logic hi_zero, lo_zero, top_zero, sec_zero;

   always_comb begin
      hi_zero  = (syn[SYN_W-1:HALF] == '0);
      lo_zero  = (syn[HALF-1:0] == '0);
      top_zero = (syn[SYN_W-1:SYN_W-NIB] == '0);
      sec_zero = (syn[SYN_W-NIB-1:HALF] == '0);
      if (hi_zero)                   chan = 1'b0;
      else if (lo_zero)              chan = 1'b1;
      else if (top_zero || sec_zero) chan = 1'b0;
      else                           chan = 1'b1;
   end
endmodule

// File: rtl/ecc_class_log.sv
module ecc_class_log #(
   parameter int PAGE_W  = 22,
   parameter int SYN_W   = 16,
   parameter bit HAS_SYN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [PAGE_W-1:0] page,
   input  logic [SYN_W-1:0]  syn,
   input  logic              clr_first,
   input  logic              clr_next,
   output logic              first_q,
   output logic              next_q,
   output logic [PAGE_W-1:0] page_log,
   output logic [SYN_W-1:0]  syn_log,
   output logic              chan_log
);
   logic load;
   assign load = evt && !first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= 1'b0;
         next_q   <= 1'b0;
         page_log <= '0;
      end else begin
         first_q <= (first_q && !clr_first) || evt;
         next_q  <= (next_q && !clr_next) || (evt && first_q);
         if (load) page_log <= page;
      end
   end

   if (HAS_SYN) begin : g_syn
      logic chan_dec;
      ecc_syn_chan #(.SYN_W(SYN_W)) u_chan (.syn(syn), .chan(chan_dec));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            syn_log  <= '0;
            chan_log <= 1'b0;
         end else if (load) begin
            syn_log  <= syn;
            chan_log <= chan_dec;
         end
      end

      AST_CHAN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (load && syn[SYN_W-1:SYN_W/2] == '0) |=> !chan_log); // R9
      AST_SYN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         first_q |=> $stable(syn_log)); // R5
   end else begin : g_nosyn
      logic unused_syn;
      assign unused_syn = ^syn;
      assign syn_log  = '0;
      assign chan_log = 1'b0;
   end

   AST_LOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |=> $stable(page_log)); // R5
   AST_LOG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (page_log == $past(page))); // R3
   AST_NEXT_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(next_q) |-> $past(first_q)); // R5
   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> first_q); // R8
   AST_CLR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_first && !evt) |=> !first_q); // R6
endmodule

// File: rtl/ecc_reg_rd.sv
module ecc_reg_rd
   import ecc_log_pkg::*;
#(
   parameter int PAGE_W  = 22,
   parameter int LOG_LSB = 6,
   parameter int SYN_W   = 16
) (
   input  logic [REG_AW-1:0] reg_addr,
   input  err_pair_t         first_bits,
   input  err_pair_t         next_bits,
   input  logic [PAGE_W-1:0] ce_page,
   input  logic [PAGE_W-1:0] ue_page,
   input  logic [SYN_W-1:0]  syn_log,
   input  logic              chan_log,
   output logic [DATA_W-1:0] rdata
);
   localparam int TOP_PAD = DATA_W - LOG_LSB - PAGE_W;

   if (TOP_PAD < 0 || SYN_W > DATA_W) begin : g_bad_fit
      $fatal(1, "ecc_reg_rd: log fields do not fit the data word");
   end

   function automatic logic [DATA_W-1:0] place_page(input logic [PAGE_W-1:0] p);
      logic [DATA_W-1:0] w;
      w = '0;
      w[LOG_LSB +: PAGE_W] = p;
      return w;
   endfunction

   always_comb begin
      rdata = '0;
      case (reg_addr)
         OFS_FIRST:   rdata[1:0] = first_bits;
         OFS_NEXT:    rdata[1:0] = next_bits;
         OFS_CE_ADDR: rdata = place_page(ce_page);
         OFS_UE_ADDR: rdata = place_page(ue_page);
         OFS_SYN:     rdata[SYN_W-1:0] = syn_log;
         OFS_CHAN:    rdata[0] = chan_log;
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W   = 34,
   parameter int PAGE_LSB = 12,
   parameter int LOG_LSB  = 6,
   parameter int SYN_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_evt,
   input  logic                ue_evt,
   input  logic [ADDR_W-1:0]   evt_addr,
   input  logic [SYN_W-1:0]    evt_syn,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq
);
   localparam int PAGE_W = ADDR_W - PAGE_LSB;

   if (PAGE_W < 1 || PAGE_LSB < 1) begin : g_bad_addr
      $fatal(1, "ecc_err_logger: ADDR_W must exceed PAGE_LSB");
   end

   logic [PAGE_W-1:0] page;
   logic              unused_bits;
   assign page        = evt_addr[ADDR_W-1:PAGE_LSB];
   assign unused_bits = ^{evt_addr[PAGE_LSB-1:0], reg_wdata[DATA_W-1:2]};

   // write-one-to-clear decode
   err_pair_t clr_first, clr_next;
   always_comb begin
      clr_first    = '0;
      clr_next     = '0;
      if (reg_wr && reg_addr == OFS_FIRST) begin
         clr_first.ce = reg_wdata[BIT_CE];
         clr_first.ue = reg_wdata[BIT_UE];
      end
      if (reg_wr && reg_addr == OFS_NEXT) begin
         clr_next.ce = reg_wdata[BIT_CE];
         clr_next.ue = reg_wdata[BIT_UE];
      end
   end

   err_pair_t         first_bits, next_bits;
   logic [PAGE_W-1:0] ce_page, ue_page;
   logic [SYN_W-1:0]  syn_log, ue_syn_unused;
   logic              chan_log, ue_chan_unused;

   ecc_class_log #(.PAGE_W(PAGE_W), .SYN_W(SYN_W), .HAS_SYN(1'b1)) u_ce (
      .clk(clk), .rst_n(rst_n), .evt(ce_evt), .page(page), .syn(evt_syn),
      .clr_first(clr_first.ce), .clr_next(clr_next.ce),
      .first_q(first_bits.ce), .next_q(next_bits.ce),
      .page_log(ce_page), .syn_log(syn_log), .chan_log(chan_log));

   ecc_class_log #(.PAGE_W(PAGE_W), .SYN_W(SYN_W), .HAS_SYN(1'b0)) u_ue (
      .clk(clk), .rst_n(rst_n), .evt(ue_evt), .page(page), .syn(evt_syn),
      .clr_first(clr_first.ue), .clr_next(clr_next.ue),
      .first_q(first_bits.ue), .next_q(next_bits.ue),
      .page_log(ue_page), .syn_log(ue_syn_unused), .chan_log(ue_chan_unused));

   logic unused_ue;
   assign unused_ue = ^{ue_syn_unused, ue_chan_unused};

   ecc_reg_rd #(.PAGE_W(PAGE_W), .LOG_LSB(LOG_LSB), .SYN_W(SYN_W)) u_rd (
      .reg_addr(reg_addr), .first_bits(first_bits), .next_bits(next_bits),
      .ce_page(ce_page), .ue_page(ue_page), .syn_log(syn_log),
      .chan_log(chan_log), .rdata(reg_rdata));

   assign irq = |{first_bits, next_bits};

   AST_IRQ_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt || ue_evt) |=> irq); // R11
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_CE_ADDR || reg_addr == OFS_UE_ADDR)
         |-> (reg_rdata[DATA_W-1:LOG_LSB+PAGE_W] == '0 && reg_rdata[LOG_LSB-1:0] == '0)); // R10
   AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_FIRST || reg_addr == OFS_NEXT) |-> reg_rdata[DATA_W-1:2] == '0); // R2
endmodule

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_evt = 1'b0, ue_evt = 1'b0;
   logic [33:0] evt_addr = '0;
   logic [15:0] evt_syn = '0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   ecc_err_logger u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] ofs, output logic [31:0] d);
      reg_addr = ofs;
      #1;
      d = reg_rdata;
   endtask

   task automatic rdchk(input string req, input logic [3:0] ofs, input logic [31:0] exp);
      logic [31:0] d;
      rd(ofs, d);
      chk(req, d, exp);
   endtask

   task automatic edge1;
      @(posedge clk);
      #1;
   endtask

   task automatic pulse(input logic ce, input logic ue, input logic [33:0] a, input logic [15:0] s);
      ce_evt = ce; ue_evt = ue; evt_addr = a; evt_syn = s;
      edge1();
      ce_evt = 0; ue_evt = 0;
   endtask

   task automatic wr(input logic [3:0] ofs, input logic [31:0] d);
      reg_addr = ofs; reg_wdata = d; reg_wr = 1;
      edge1();
      reg_wr = 0;
   endtask

   function automatic logic [31:0] logv(input logic [33:0] a);
      return {4'b0, a[33:12], 6'b0};
   endfunction

   function automatic logic exp_chan(input logic [15:0] s);
      if (s[15:8] == 0) return 1'b0;
      if (s[7:0] == 0) return 1'b1;
      if (s[15:12] == 0 || s[11:8] == 0) return 1'b0;
      return 1'b1;
   endfunction

   task automatic clear_all;
      wr(4'd0, 32'h3);
      wr(4'd1, 32'h3);
   endtask

   task automatic t_reset;
      for (int o = 0; o < 16; o++) rdchk("R1", o[3:0], 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_ce_first;
      logic [33:0] a = 34'h2_ABCD_E123;
      pulse(1, 0, a, 16'h00F5);
      rdchk("R3 first", 4'd0, 32'h1);
      rdchk("R3 addr", 4'd2, logv(a));
      rdchk("R10 addr", 4'd2, 32'h0AAF_3780);
      rdchk("R3 syn", 4'd4, 32'h00F5);
      rdchk("R3 chan", 4'd5, 32'h0);
      rdchk("R2 next", 4'd1, 32'h0);
      chk("R11 irq", {31'b0, irq}, 32'h1);
   endtask

   task automatic t_ce_overflow;
      pulse(1, 0, 34'h1_1111_1000, 16'hAB12);
      rdchk("R5 first", 4'd0, 32'h1);
      rdchk("R5 next", 4'd1, 32'h1);
      rdchk("R5 addr kept", 4'd2, logv(34'h2_ABCD_E123));
      rdchk("R5 syn kept", 4'd4, 32'h00F5);
      rdchk("R5 chan kept", 4'd5, 32'h0);
   endtask

   task automatic t_ue;
      logic [33:0] a = 34'h3_FFFF_FFFF;
      pulse(0, 1, a, 16'h1234);
      rdchk("R4 first", 4'd0, 32'h3);
      rdchk("R4 addr", 4'd3, logv(a));
      rdchk("R10 ue addr", 4'd3, 32'h0FFF_FFC0);
      rdchk("R4 syn untouched", 4'd4, 32'h00F5);
      pulse(0, 1, 34'h0_0000_5000, 16'h0);
      rdchk("R5 ue next", 4'd1, 32'h3);
      rdchk("R5 ue addr kept", 4'd3, logv(a));
   endtask

   task automatic t_w1c;
      wr(4'd0, 32'h0);
      rdchk("R6 zero write", 4'd0, 32'h3);
      wr(4'd1, 32'hFFFF_FFFE);
      rdchk("R6 next ue cleared", 4'd1, 32'h1);
      wr(4'd0, 32'h1);
      rdchk("R6 first ce cleared", 4'd0, 32'h2);
      rdchk("R6 log kept", 4'd2, logv(34'h2_ABCD_E123));
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd4, 32'hFFFF_FFFF);
      wr(4'd9, 32'hFFFF_FFFF);
      rdchk("R12 ce log", 4'd2, logv(34'h2_ABCD_E123));
      rdchk("R12 syn log", 4'd4, 32'h00F5);
      rdchk("R12 status", 4'd0, 32'h2);
      rdchk("R12 unmapped", 4'd9, 32'h0);
      clear_all();
      rdchk("R6 all cleared", 4'd0, 32'h0);
      rdchk("R6 next cleared", 4'd1, 32'h0);
      chk("R11 irq low", {31'b0, irq}, 32'h0);
      rdchk("R6 ue log kept", 4'd3, logv(34'h3_FFFF_FFFF));
   endtask

   task automatic t_rearm;
      logic [33:0] a = 34'h0_0765_4000;
      pulse(1, 0, a, 16'hAB00);
      rdchk("R7 addr reload", 4'd2, logv(a));
      rdchk("R7 syn reload", 4'd4, 32'hAB00);
      rdchk("R7 chan reload", 4'd5, 32'h1);
      rdchk("R7 next clear", 4'd1, 32'h0);
   endtask

   task automatic t_collide;
      // first ce bit set: event + clear same edge
      ce_evt = 1; evt_addr = 34'h1_0000_0000; evt_syn = 16'h00FF;
      reg_addr = 4'd0; reg_wdata = 32'h1; reg_wr = 1;
      edge1();
      ce_evt = 0; reg_wr = 0;
      rdchk("R8 first stays", 4'd0, 32'h1);
      rdchk("R8 next set", 4'd1, 32'h1);
      clear_all();
      // ue: clear next while overflow event
      pulse(0, 1, 34'h0, 16'h0);
      ue_evt = 1; reg_addr = 4'd1; reg_wdata = 32'h2; reg_wr = 1;
      edge1();
      ue_evt = 0; reg_wr = 0;
      rdchk("R8 next ue stays", 4'd1, 32'h2);
      clear_all();
      chk("R11 irq cleared", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_chan;
      logic [15:0] pats [6] = '{16'h00FF, 16'hAB00, 16'h0A12, 16'hA012, 16'hAB12, 16'h0000};
      foreach (pats[i]) begin
         pulse(1, 0, 34'h0, pats[i]);
         rdchk("R9 chan", 4'd5, {31'b0, exp_chan(pats[i])});
         rdchk("R9 syn", 4'd4, {16'b0, pats[i]});
         wr(4'd0, 32'h1);
      end
      rdchk("R9 status", 4'd0, 32'h0);
   endtask

   task automatic t_both;
      pulse(1, 1, 34'h2_0000_3000, 16'h0100);
      rdchk("R2 both first", 4'd0, 32'h3);
      rdchk("R3 both ce", 4'd2, logv(34'h2_0000_3000));
      rdchk("R4 both ue", 4'd3, logv(34'h2_0000_3000));
      wr(4'd0, 32'h2);
      chk("R11 irq one bit", {31'b0, irq}, 32'h1);
      wr(4'd0, 32'h1);
      chk("R11 irq none", {31'b0, irq}, 32'h0);
   endtask

   bit done = 0;

   initial begin
      #35 rst_n = 1;
      edge1();
      t_reset();
      t_ce_first();
      t_ce_overflow();
      t_ue();
      t_w1c();
      t_rearm();
      t_collide();
      t_chan();
      t_both();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule